// File: doc/BRIEF.md
# Bit-Serial Word Link with Hardware Retry

This block is a matched sender and receiver for a point-to-point bit-serial link. Both ends run on one shared link clock. The sender accepts a 32-bit word on a valid/ready interface and serialises it as a frame on a single forward wire. The frame is a start bit, then the data least-significant bit first, then an even parity bit. The sender then waits for a three-bit acknowledgement on a return wire.

The receiver frames the incoming bits and checks parity. A word that passes is delivered as a one-cycle strobe. The receiver answers accept or resend. On any answer other than accept, the sender replays the held word at once, with no outside help. It also bumps a saturating error counter that can be cleared synchronously.

Two channel-fault inputs model noise on the wires. Each one XORs a bit onto one of the two wires for the cycle in which it is high. The post-fault wire levels are brought out for observation.

Top module: `serial_word_link`

## Requirements
- R1: After reset, tx_ready_o is 1, rx_valid_o is 0, err_cnt_o is 0, and both wires are at the idle level 0.
- R2: Starting the cycle after a word is accepted, the forward wire carries 34 bits, one per cycle: a 1 (start), the 32 data bits LSB first, then the even parity bit (XOR of the data bits). Otherwise the wire rests at 0.
- R3: A frame whose parity checks delivers its word on rx_data_o with rx_valid_o high for exactly one cycle.
- R4: A frame whose parity fails is never delivered.
- R5: The return wire carries a 1 (start), then two code bits, first bit first: 1,0 means accept; 0,1 means parity failure and resend. The start bit appears in the cycle after the parity bit.
- R6: tx_ready_o stays low from acceptance until an accept code arrives. A retry reuses the word captured at acceptance, whatever tx_data_i does meanwhile.
- R7: Any code other than 1,0 (including 0,0 and 1,1) causes a resend, even when the word was already delivered.
- R8: err_cnt_o increases by exactly one for each resend request the sender receives.
- R9: err_cnt_o saturates at its maximum value (all ones, ERR_W bits, default 16).
- R10: err_clr_i clears err_cnt_o on the next clock edge and takes priority over a simultaneous increment.
- R11: A clean transfer keeps tx_ready_o low for 37 cycles (start, 32 data, parity, 3-bit reply), and each retry adds another 37.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | WORD_W | Word offered for sending |
| tx_valid_i | input | 1 | Word offered |
| tx_ready_o | output | 1 | Sender idle; word taken when valid is also high |
| fwd_flip_i | input | 1 | Channel fault: invert forward wire this cycle |
| ack_flip_i | input | 1 | Channel fault: invert return wire this cycle |
| fwd_line_o | output | 1 | Forward wire as seen by the receiver |
| ack_line_o | output | 1 | Return wire as seen by the sender |
| rx_data_o | output | WORD_W | Last delivered word |
| rx_valid_o | output | 1 | One-cycle delivery strobe |
| err_clr_i | input | 1 | Synchronous clear of the error counter |
| err_cnt_o | output | ERR_W | Saturating count of resend requests |

## Verification
The hardest cases to reach are faults on the return wire, which turn a delivered word into a duplicate, and a counter clear that lands on the same edge as a resend decision. The bench measures every transfer in cycles from the acceptance edge and drives the fault inputs at exact offsets within that frame. The offsets pick a data bit, the parity bit or a reply bit, and the clear edge. Random words and fault kinds are then mixed in, with a narrow counter so that saturation is reached quickly.

// File: rtl/link_pkg.sv
package link_pkg;
  localparam int WORD_W_DEF = 32;
  localparam int ERR_W_DEF  = 16;
  localparam logic [1:0] ACK_OK     = 2'b10;
  localparam logic [1:0] ACK_RESEND = 2'b01;

  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_WAIT} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_DATA, RX_PAR, RX_ACK} rx_state_e;
endpackage

// File: rtl/err_counter.sv
module err_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (inc_i && cnt_q != '1) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/link_tx.sv
module link_tx
  import link_pkg::*;
#(
  parameter int WORD_W = WORD_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              line_o,
  input  logic              ack_line_i,
  output logic              resend_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] PAR_POS = CNT_W'(WORD_W + 1);

  tx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] word_q, shift_q;
  logic              par_q;
  logic [1:0]        ph_q;
  logic              hi_q;
  logic              reply_done;

  assign ready_o    = (state_q == TX_IDLE);
  assign reply_done = (state_q == TX_WAIT) && (ph_q == 2'd2);
  assign resend_o   = reply_done && ({hi_q, ack_line_i} != ACK_OK);

  always_comb begin
    line_o = 1'b0;
    if (state_q == TX_SEND) begin
      if (cnt_q == '0)          line_o = 1'b1;
      else if (cnt_q == PAR_POS) line_o = par_q;
      else                      line_o = shift_q[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      word_q  <= '0;
      shift_q <= '0;
      par_q   <= 1'b0;
      ph_q    <= '0;
      hi_q    <= 1'b0;
    end else begin
      case (state_q)
        TX_IDLE: if (valid_i) begin
          word_q  <= data_i;
          shift_q <= data_i;
          par_q   <= ^data_i;
          cnt_q   <= '0;
          state_q <= TX_SEND;
        end
        TX_SEND: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q != '0 && cnt_q != PAR_POS) shift_q <= shift_q >> 1;
          if (cnt_q == PAR_POS) begin
            state_q <= TX_WAIT;
            ph_q    <= '0;
          end
        end
        TX_WAIT: begin
          case (ph_q)
            2'd0:    if (ack_line_i) ph_q <= 2'd1;
            2'd1:    begin hi_q <= ack_line_i; ph_q <= 2'd2; end
            default: begin
              ph_q <= '0;
              if (resend_o) begin
                // replay the held word from the start bit
                shift_q <= word_q;
                cnt_q   <= '0;
                state_q <= TX_SEND;
              end else begin
                state_q <= TX_IDLE;
              end
            end
          endcase
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/link_rx.sv
module link_rx
  import link_pkg::*;
#(
  parameter int WORD_W = WORD_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  output logic              ack_line_o,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shift_q, data_q;
  logic              valid_q;
  logic [1:0]        code_q;
  logic              par_ok;

  assign par_ok  = ((^shift_q) == line_i);
  assign data_o  = data_q;
  assign valid_o = valid_q;

  always_comb begin
    ack_line_o = 1'b0;
    if (state_q == RX_ACK) begin
      case (cnt_q)
        CNT_W'(0): ack_line_o = 1'b1;
        CNT_W'(1): ack_line_o = code_q[1];
        default:   ack_line_o = code_q[0];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      code_q  <= ACK_RESEND;
    end else begin
      valid_q <= 1'b0;
      case (state_q)
        RX_IDLE: if (line_i) begin
          cnt_q   <= '0;
          state_q <= RX_DATA;
        end
        RX_DATA: begin
          shift_q <= {line_i, shift_q[WORD_W-1:1]};
          cnt_q   <= cnt_q + CNT_W'(1);
          if (cnt_q == LAST_BIT) state_q <= RX_PAR;
        end
        RX_PAR: begin
          if (par_ok) begin
            data_q  <= shift_q;
            valid_q <= 1'b1;
          end
          code_q  <= par_ok ? ACK_OK : ACK_RESEND;
          cnt_q   <= '0;
          state_q <= RX_ACK;
        end
        RX_ACK: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(2)) state_q <= RX_IDLE;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_word_link.sv
module serial_word_link
  import link_pkg::*;
#(
  parameter int WORD_W = WORD_W_DEF,
  parameter int ERR_W  = ERR_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic              fwd_flip_i,
  input  logic              ack_flip_i,
  output logic              fwd_line_o,
  output logic              ack_line_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              err_clr_i,
  output logic [ERR_W-1:0]  err_cnt_o
);
  logic tx_line, rx_ack, resend;

  // channel model: fault inputs corrupt the wires between the endpoints
  assign fwd_line_o = tx_line ^ fwd_flip_i;
  assign ack_line_o = rx_ack ^ ack_flip_i;

  link_tx #(.WORD_W(WORD_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_i     (tx_data_i),
    .valid_i    (tx_valid_i),
    .ready_o    (tx_ready_o),
    .line_o     (tx_line),
    .ack_line_i (ack_line_o),
    .resend_o   (resend)
  );

  link_rx #(.WORD_W(WORD_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (fwd_line_o),
    .ack_line_o (rx_ack),
    .data_o     (rx_data_o),
    .valid_o    (rx_valid_o)
  );

  err_counter #(.W(ERR_W)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (err_clr_i),
    .inc_i  (resend),
    .cnt_o  (err_cnt_o)
  );
endmodule

// File: rtl/serial_word_link_chk.sv
module serial_word_link_chk #(
  parameter int ERR_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_valid_i,
  input logic             tx_ready_o,
  input logic             fwd_flip_i,
  input logic             fwd_line_o,
  input logic             rx_valid_o,
  input logic             err_clr_i,
  input logic [ERR_W-1:0] err_cnt_o
);
  assert_idle_line_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_o && !fwd_flip_i) |-> !fwd_line_o);

  assert_single_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  assert_idle_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_o && !tx_valid_i) |=> tx_ready_o);

  assert_step_one_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_clr_i |=> (err_cnt_o == $past(err_cnt_o)) ||
                   (err_cnt_o == $past(err_cnt_o) + ERR_W'(1)));

  assert_saturate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o == '1 && !err_clr_i) |=> err_cnt_o == '1);

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i |=> err_cnt_o == '0);
endmodule

bind serial_word_link serial_word_link_chk #(.ERR_W(ERR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_valid_i (tx_valid_i),
  .tx_ready_o (tx_ready_o),
  .fwd_flip_i (fwd_flip_i),
  .fwd_line_o (fwd_line_o),
  .rx_valid_o (rx_valid_o),
  .err_clr_i  (err_clr_i),
  .err_cnt_o  (err_cnt_o)
);

// File: tb/serial_word_link_tb.sv
`timescale 1ns/1ps
module serial_word_link_tb;
  localparam int EW  = 4;
  localparam int MAXE = (1 << EW) - 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [31:0] tx_data_i = '0;
  logic tx_valid_i = 1'b0, fwd_flip_i = 1'b0, ack_flip_i = 1'b0, err_clr_i = 1'b0;
  logic tx_ready_o, fwd_line_o, ack_line_o, rx_valid_o;
  logic [31:0] rx_data_o;
  logic [EW-1:0] err_cnt_o;

  int n_run = 0, n_fail = 0, rx_cnt = 0, exp_err = 0;
  logic [31:0] rx_last = '0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_word_link #(.WORD_W(32), .ERR_W(EW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .fwd_flip_i(fwd_flip_i), .ack_flip_i(ack_flip_i),
    .fwd_line_o(fwd_line_o), .ack_line_o(ack_line_o), .rx_data_o(rx_data_o),
    .rx_valid_o(rx_valid_o), .err_clr_i(err_clr_i), .err_cnt_o(err_cnt_o));

  always @(negedge clk) if (rx_valid_o) begin
    rx_cnt  <= rx_cnt + 1;
    rx_last <= rx_data_o;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [33:0] frame_of(input logic [31:0] d);
    return {^d, d, 1'b1};
  endfunction

  // fbit: data/parity bit index to corrupt on the first attempt (-1 none)
  // abit: reply code bit to corrupt on the first attempt (-1 none)
  // clr_at: cycle offset at which err_clr_i is raised (-1 none)
  task automatic xfer(input logic [31:0] d, input int fbit, input int abit, input int clr_at);
    int c, rx0, exp_rx, exp_cyc;
    logic [33:0] frm;
    logic [2:0] ack, exp_ack;
    bit retry;
    retry = (fbit >= 0) || (abit >= 0);
    rx0 = rx_cnt;
    frm = '0; ack = '0;
    @(negedge clk); tx_data_i = d; tx_valid_i = 1'b1;
    @(posedge clk);
    c = 0;
    forever begin
      @(negedge clk);
      tx_valid_i = 1'b0;
      tx_data_i  = $urandom();
      if (c > 0 && tx_ready_o) break;
      fwd_flip_i = (fbit >= 0) && (c == 1 + fbit);
      ack_flip_i = (abit >= 0) && (c == 35 + abit);
      err_clr_i  = (clr_at >= 0) && (c == clr_at);
      #1;
      if (c < 34) frm[c] = fwd_line_o;
      else if (c < 37) ack[36 - c] = ack_line_o;
      c++;
      if (c > 400) break;
      @(posedge clk);
    end
    fwd_flip_i = 1'b0; ack_flip_i = 1'b0; err_clr_i = 1'b0;
    if (retry) begin
      if (clr_at == 36) exp_err = 0;
      else if (exp_err < MAXE) exp_err++;
    end
    exp_cyc = retry ? 74 : 37;
    exp_rx  = (abit >= 0) ? 2 : 1;
    if (fbit >= 0) exp_ack = 3'b101;
    else if (abit == 0) exp_ack = 3'b100;
    else if (abit == 1) exp_ack = 3'b111;
    else exp_ack = 3'b110;
    chk(c == exp_cyc, "R11/R6 busy cycles", c, exp_cyc);
    chk(rx_cnt - rx0 == exp_rx, "R3/R4/R7 deliveries", rx_cnt - rx0, exp_rx);
    chk(rx_last == d, "R3/R6 delivered word", rx_last, d);
    chk(err_cnt_o == EW'(exp_err), "R8/R9/R10 error count", err_cnt_o, exp_err);
    chk(ack == exp_ack, "R5 reply code", ack, exp_ack);
    if (fbit < 0) chk(frm == frame_of(d), "R2 frame bits", frm, frame_of(d));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tx_ready_o == 1'b1, "R1 ready", tx_ready_o, 1);
    chk(rx_valid_o == 1'b0, "R1 rx_valid", rx_valid_o, 0);
    chk(err_cnt_o == '0, "R1 err", err_cnt_o, 0);
    chk(fwd_line_o == 1'b0 && ack_line_o == 1'b0, "R1 idle wires", {fwd_line_o, ack_line_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    xfer(32'hA5A5_F00F, -1, -1, -1);
    xfer(32'h0000_0000, -1, -1, -1);
    xfer(32'hFFFF_FFFF, -1, -1, -1);
    xfer(32'h1234_5678, 0, -1, -1);   // R4 first data bit
    xfer(32'h8765_4321, 31, -1, -1);  // R4 last data bit
    xfer(32'hDEAD_BEEF, 32, -1, -1);  // R4 parity bit
    xfer(32'h0F0F_0F0F, -1, 0, -1);   // R7 accept turned into 0,0
    xfer(32'hF0F0_F0F0, -1, 1, -1);   // R7 accept turned into 1,1

    // R9: drive the counter to saturation and past it
    for (int i = 0; i < MAXE; i++) xfer($urandom(), $urandom_range(0, 32), -1, -1);
    chk(err_cnt_o == EW'(MAXE), "R9 saturated", err_cnt_o, MAXE);

    // R10: plain clear
    @(negedge clk); err_clr_i = 1'b1;
    @(negedge clk); err_clr_i = 1'b0;
    exp_err = 0;
    chk(err_cnt_o == '0, "R10 clear", err_cnt_o, 0);

    // R10: clear on the same edge as a resend decision
    xfer(32'h5555_AAAA, 7, -1, -1);
    xfer(32'hAAAA_5555, 9, -1, 36);

    for (int i = 0; i < 80; i++) begin
      int kind;
      kind = $urandom_range(0, 3);
      case (kind)
        2:       xfer($urandom(), $urandom_range(0, 32), -1, -1);
        3:       xfer($urandom(), -1, $urandom_range(0, 1), -1);
        default: xfer($urandom(), -1, -1, -1);
      endcase
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule